// File: doc/BRIEF.md
# Synchronous Smart-Card Bit Sequencer

This block generates the card clock and drives or samples the IO line of a synchronous smart card that frames its data with clock start/stop conditions. A divided card clock runs from the system clock and can be frozen at a chosen level. A reloadable bit-length counter advances once per falling card-clock edge and raises a sticky interrupt when it reaches the programmed length.

In transmit mode, the data bits are shifted out LSB first from an eight-entry byte FIFO. A new byte is popped at the start of each group of eight bits. When the counter is at zero or at its limit, the IO output is taken from a software override bit. Software forms start and stop conditions itself: it freezes the clock high, sets the override level, reloads the counter and then releases the clock.

In receive mode, the card's IO is sampled on rising card-clock edges and assembled LSB first into a byte register with a valid flag. An optional two-wire style mode captures the level of the final (limit) slot as an acknowledge bit.

Top module: `sync_card_seq`

## Requirements
- R1: While the clock is not stopped, the card clock toggles every CLK_DIV system cycles, so successive falling edges are 2*CLK_DIV cycles apart.
- R2: While clock stop is high, the card clock output equals the stop-level input, no card-clock edge occurs and the length count does not change.
- R3: A reload pulse sets the count to 0 and latches the new limit. A reload takes priority over a falling edge in the same cycle.
- R4: On each falling card-clock edge, the count increments by one until it equals the limit. It then holds there.
- R5: The length interrupt rises on the edge where the count reaches the limit. It stays high until a clear pulse arrives. If a set and a clear fall in the same cycle, the set wins.
- R6: In transmit mode (tx_mode_i=1), io_o equals io_ovr_i when the count is 0 or equals the limit. Otherwise io_o is the current FIFO data bit, which changes on the falling edge. In receive mode (tx_mode_i=0), io_o always equals io_ovr_i.
- R7: io_oe_o always follows io_dir_i (1 = drive, 0 = release).
- R8: The FIFO holds up to FIFO_DEPTH bytes and shows full and empty flags. Transmit bits are sent LSB first. One byte is popped when bit 0 of each 8-bit group is launched. With the FIFO empty, that group sends all ones.
- R9: A write while the FIFO is full is discarded, and fifo_ovf_o becomes and stays 1.
- R10: In receive mode, io_i is sampled on each rising edge while the count is strictly between 0 and the limit, LSB first. After 8 samples, rx_byte_o holds the byte and rx_valid_o is 1. A reload clears rx_valid_o.
- R11: With two_wire_i=1, the rising edge in the slot where the count equals a non-zero limit copies io_i to ack_o. With two_wire_i=0, ack_o is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| len_reload_i | input | 1 | Reload pulse for the length counter |
| len_value_i | input | LEN_W | Limit loaded on reload |
| irq_clr_i | input | 1 | Clears the pending length interrupt |
| clk_stop_i | input | 1 | Freezes the card clock |
| clk_stop_lvl_i | input | 1 | Level held while frozen |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| io_ovr_i | input | 1 | Software IO level |
| io_dir_i | input | 1 | 1 = drive IO, 0 = release |
| two_wire_i | input | 1 | Enables acknowledge capture in the limit slot |
| fifo_wr_i | input | 1 | FIFO write strobe |
| fifo_wdata_i | input | DW | FIFO write byte |
| io_i | input | 1 | Level seen on the card IO pin |
| card_clk_o | output | 1 | Card clock |
| io_o | output | 1 | IO output value |
| io_oe_o | output | 1 | IO output enable |
| len_count_o | output | LEN_W | Current bit count |
| len_irq_o | output | 1 | Pending length interrupt |
| fifo_full_o | output | 1 | FIFO full |
| fifo_empty_o | output | 1 | FIFO empty |
| fifo_ovf_o | output | 1 | Sticky overflow flag |
| rx_byte_o | output | DW | Last received byte |
| rx_valid_o | output | 1 | Received byte valid |
| ack_o | output | 1 | Captured acknowledge level |

## Verification
Two events can land in the same cycle. The falling edge that brings the count to its limit sets the interrupt, while software may be clearing it. Separately, a reload can coincide with a falling edge that would otherwise advance the count.

The bench provokes the first case by holding the clear input high through a whole short frame. It judges the result by seeing the interrupt high at the limit edge and low one cycle later. It provokes the second by holding reload high across several running card clocks, and it expects the count to stay at zero and then advance once reload drops.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
    typedef enum logic {
        XFER_RX = 1'b0,
        XFER_TX = 1'b1
    } xfer_dir_e;
endpackage

// File: rtl/scs_clkgen.sv
`timescale 1ns/1ps
module scs_clkgen #(
    parameter int CLK_DIV = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_i,
    input  logic stop_lvl_i,
    output logic card_clk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic          clk;
    } gen_t;

    gen_t q, d;

    always_comb begin
        d      = q;
        rise_o = 1'b0;
        fall_o = 1'b0;
        if (stop_i) begin
            d.clk = stop_lvl_i;
            d.ph  = '0;
        end else if (q.ph == PH_LAST) begin
            d.ph   = '0;
            d.clk  = ~q.clk;
            rise_o = ~q.clk;
            fall_o = q.clk;
        end else begin
            d.ph = q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign card_clk_o = stop_i ? stop_lvl_i : q.clk;

    a_r2_no_edge_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |-> !(rise_o || fall_o));
    a_r1_edges_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_o && fall_o));
endmodule

// File: rtl/scs_len_counter.sv
`timescale 1ns/1ps
module scs_len_counter #(
    parameter int LEN_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_i,
    input  logic             reload_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             irq_clr_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic [LEN_W-1:0] lim_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] lim;
        logic             irq;
    } len_t;

    len_t q, d;
    logic [LEN_W-1:0] nxt;

    always_comb begin
        d   = q;
        nxt = q.cnt + 1'b1;
        if (irq_clr_i) d.irq = 1'b0;
        if (reload_i) begin
            d.cnt = '0;
            d.lim = len_i;
        end else if (fall_i && (q.cnt != q.lim)) begin
            d.cnt = nxt;
            if (nxt == q.lim) d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign cnt_o = q.cnt;
    assign lim_o = q.lim;
    assign irq_o = q.irq;

    a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= q.lim);
    a_r3_reload_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reload_i |=> (q.cnt == '0));
    a_r2_frozen_without_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fall_i && !reload_i) |=> $stable(q.cnt));
    a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.irq && !irq_clr_i) |=> q.irq);
endmodule

// File: rtl/scs_tx_fifo.sv
`timescale 1ns/1ps
module scs_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          rd_i,
    output logic [DW-1:0] rdata_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CNT_FULL = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            rp;
        logic [AW-1:0]            wp;
        logic [AW:0]              cnt;
        logic                     ovf;
    } fifo_t;

    fifo_t q, d;
    logic do_wr, do_rd;

    always_comb begin
        d     = q;
        do_wr = wr_i && (q.cnt != CNT_FULL);
        do_rd = rd_i && (q.cnt != '0);
        if (wr_i && !do_wr) d.ovf = 1'b1;
        if (do_wr) begin
            d.mem[q.wp] = wdata_i;
            d.wp        = (q.wp == PTR_LAST) ? '0 : q.wp + 1'b1;
        end
        if (do_rd) d.rp = (q.rp == PTR_LAST) ? '0 : q.rp + 1'b1;
        d.cnt = q.cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign rdata_o = q.mem[q.rp];
    assign full_o  = (q.cnt == CNT_FULL);
    assign empty_o = (q.cnt == '0);
    assign ovf_o   = q.ovf;

    a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.cnt <= CNT_FULL);
    a_r9_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (full_o && wr_i && !rd_i) |=> $stable(q.cnt));
    a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.ovf |=> q.ovf);
endmodule

// File: rtl/sync_card_seq.sv
`timescale 1ns/1ps
module sync_card_seq
    import scs_pkg::*;
#(
    parameter int DW         = 8,
    parameter int FIFO_DEPTH = 8,
    parameter int LEN_W      = 8,
    parameter int CLK_DIV    = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             len_reload_i,
    input  logic [LEN_W-1:0] len_value_i,
    input  logic             irq_clr_i,
    input  logic             clk_stop_i,
    input  logic             clk_stop_lvl_i,
    input  logic             tx_mode_i,
    input  logic             io_ovr_i,
    input  logic             io_dir_i,
    input  logic             two_wire_i,
    input  logic             fifo_wr_i,
    input  logic [DW-1:0]    fifo_wdata_i,
    input  logic             io_i,
    output logic             card_clk_o,
    output logic             io_o,
    output logic             io_oe_o,
    output logic [LEN_W-1:0] len_count_o,
    output logic             len_irq_o,
    output logic             fifo_full_o,
    output logic             fifo_empty_o,
    output logic             fifo_ovf_o,
    output logic [DW-1:0]    rx_byte_o,
    output logic             rx_valid_o,
    output logic             ack_o
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    typedef struct packed {
        logic [DW-1:0] tsh;
        logic [BW-1:0] tbit;
        logic [DW-1:0] rsh;
        logic [BW-1:0] rbit;
        logic [DW-1:0] rbyte;
        logic          rvalid;
        logic          ack;
    } seq_t;

    seq_t q, d;

    logic             rise, fall;
    logic [LEN_W-1:0] cnt, lim, cnt_nxt;
    logic             pop;
    logic [DW-1:0]    head;
    logic             is_tx, at_edge, at_lim, cnt_nz, adv_data, rx_take;
    logic [DW-1:0]    rsh_nxt;

    scs_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stop_i     (clk_stop_i),
        .stop_lvl_i (clk_stop_lvl_i),
        .card_clk_o (card_clk_o),
        .rise_o     (rise),
        .fall_o     (fall)
    );

    scs_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fall_i    (fall),
        .reload_i  (len_reload_i),
        .len_i     (len_value_i),
        .irq_clr_i (irq_clr_i),
        .cnt_o     (cnt),
        .lim_o     (lim),
        .irq_o     (len_irq_o)
    );

    scs_tx_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (fifo_wr_i),
        .wdata_i (fifo_wdata_i),
        .rd_i    (pop),
        .rdata_o (head),
        .full_o  (fifo_full_o),
        .empty_o (fifo_empty_o),
        .ovf_o   (fifo_ovf_o)
    );

    always_comb begin
        d        = q;
        pop      = 1'b0;
        is_tx    = (xfer_dir_e'(tx_mode_i) == XFER_TX);
        cnt_nz   = (cnt != '0);
        at_lim   = (cnt == lim);
        at_edge  = !cnt_nz || at_lim;
        cnt_nxt  = cnt + 1'b1;
        adv_data = fall && !len_reload_i && is_tx && !at_lim && (cnt_nxt != lim);
        rx_take  = rise && !is_tx && cnt_nz && !at_lim;
        rsh_nxt  = {io_i, q.rsh[DW-1:1]};

        if (len_reload_i) begin
            d.tbit   = '0;
            d.rbit   = '0;
            d.rvalid = 1'b0;
        end else begin
            if (adv_data) begin
                if (q.tbit == '0) begin
                    d.tsh = fifo_empty_o ? '1 : head;
                    pop   = !fifo_empty_o;
                end else begin
                    d.tsh = q.tsh >> 1;
                end
                d.tbit = (q.tbit == BIT_LAST) ? '0 : q.tbit + 1'b1;
            end
            if (rx_take) begin
                d.rsh = rsh_nxt;
                if (q.rbit == BIT_LAST) begin
                    d.rbyte  = rsh_nxt;
                    d.rvalid = 1'b1;
                    d.rbit   = '0;
                end else begin
                    d.rbit = q.rbit + 1'b1;
                end
            end
            if (rise && two_wire_i && at_lim && cnt_nz) d.ack = io_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign io_o        = (is_tx && !at_edge) ? q.tsh[0] : io_ovr_i;
    assign io_oe_o     = io_dir_i;
    assign len_count_o = cnt;
    assign rx_byte_o   = q.rbyte;
    assign rx_valid_o  = q.rvalid;
    assign ack_o       = q.ack;

    a_r10_reload_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        len_reload_i |=> !rx_valid_o);
    a_r8_pop_only_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pop |-> (tx_mode_i && fall && !fifo_empty_o));
    a_r11_ack_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !two_wire_i |=> $stable(ack_o));
endmodule

// File: tb/sync_card_seq_tb.sv
`timescale 1ns/1ps
module sync_card_seq_tb;
    localparam int DW = 8, DEPTH = 8, LW = 8, DIV = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reload = 0, irq_clr = 0, stop = 0, lvl = 0, tx = 0;
    logic ovr = 0, dir = 0, two_wire = 0, wr = 0, io_in = 0;
    logic [LW-1:0] len_v = '0;
    logic [DW-1:0] wdata = '0;
    logic card_clk, io_o, io_oe, irq, full, empty, ovf, rx_valid, ack;
    logic [LW-1:0] cnt;
    logic [DW-1:0] rx_byte;

    int n_run = 0, n_fail = 0;
    longint cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_card_seq #(.DW(DW), .FIFO_DEPTH(DEPTH), .LEN_W(LW), .CLK_DIV(DIV)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .len_reload_i(reload), .len_value_i(len_v),
        .irq_clr_i(irq_clr), .clk_stop_i(stop), .clk_stop_lvl_i(lvl), .tx_mode_i(tx),
        .io_ovr_i(ovr), .io_dir_i(dir), .two_wire_i(two_wire), .fifo_wr_i(wr),
        .fifo_wdata_i(wdata), .io_i(io_in), .card_clk_o(card_clk), .io_o(io_o),
        .io_oe_o(io_oe), .len_count_o(cnt), .len_irq_o(irq), .fifo_full_o(full),
        .fifo_empty_o(empty), .fifo_ovf_o(ovf), .rx_byte_o(rx_byte),
        .rx_valid_o(rx_valid), .ack_o(ack)
    );

    function automatic logic [7:0] tx_byte(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        logic p;
        do begin p = card_clk; @(negedge clk); end while (!(p && !card_clk));
    endtask

    task automatic wait_rise();
        logic p;
        do begin p = card_clk; @(negedge clk); end while (!(!p && card_clk));
    endtask

    task automatic start_frame(input int len, input logic mode);
        stop = 1; lvl = 1; @(negedge clk);
        chk(card_clk == 1'b1, "R2 stop level high", card_clk, 1);
        ovr = 0; tx = mode; reload = 1; len_v = LW'(len); @(negedge clk);
        reload = 0; @(negedge clk);
        chk(cnt == 0, "R3 reload count", cnt, 0);
        stop = 0;
    endtask

    task automatic end_frame();
        stop = 1; lvl = 1; @(negedge clk);
        irq_clr = 1; @(negedge clk);
        irq_clr = 0;
        chk(irq == 1'b0, "R5 irq cleared", irq, 0);
    endtask

    task automatic tx_frame(input int len, input int first);
        longint t_prev = 0;
        start_frame(len, 1'b1);
        chk(io_o == 1'b0, "R6 override at count 0", io_o, 0);
        for (int k = 1; k <= len; k++) begin
            wait_fall();
            chk(cnt == LW'(k), "R4 count step", cnt, k);
            if (k >= 2) chk(cyc - t_prev == 2 * DIV, "R1 card clock period", cyc - t_prev, 2 * DIV);
            t_prev = cyc;
            if (k < len) begin
                logic [7:0] b;
                logic eb;
                b  = tx_byte(first + (k - 1) / 8);
                eb = b[(k - 1) % 8];
                chk(io_o == eb, "R8 fifo data bit", io_o, eb);
                chk(irq == 1'b0, "R5 irq low before limit", irq, 0);
            end else begin
                chk(irq == 1'b1, "R5 irq at limit", irq, 1);
                chk(io_o == ovr, "R6 override at limit", io_o, ovr);
            end
        end
        wait_fall();
        chk(cnt == LW'(len), "R4 hold at limit", cnt, len);
        ovr = 1; @(negedge clk);
        chk(io_o == 1'b1, "R6 stop level override", io_o, 1);
        ovr = 0;
        end_frame();
    endtask

    task automatic rx_frame(input logic [7:0] pat);
        dir = 0;
        start_frame(9, 1'b0);
        chk(rx_valid == 1'b0, "R10 valid cleared by reload", rx_valid, 0);
        chk(io_oe == 1'b0, "R7 released", io_oe, 0);
        for (int k = 1; k <= 9; k++) begin
            wait_fall();
            if (k <= 8) io_in = pat[k - 1];
        end
        chk(rx_valid == 1'b1, "R10 valid after 8 bits", rx_valid, 1);
        chk(rx_byte == pat, "R10 byte lsb first", rx_byte, pat);
        end_frame();
    endtask

    task automatic ack_frame(input logic tw, input logic v, input logic exp);
        two_wire = tw; dir = 0;
        start_frame(9, 1'b1);
        for (int k = 1; k <= 9; k++) begin
            wait_fall();
            if (k <= 8) chk(io_o == 1'b1, "R8 empty fifo sends ones", io_o, 1);
        end
        io_in = v;
        wait_rise();
        chk(ack == exp, "R11 ack slot", ack, exp);
        end_frame();
        two_wire = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; @(negedge clk);
        chk(cnt == 0, "R4 reset count", cnt, 0);
        chk(irq == 0, "R5 reset irq", irq, 0);
        chk(empty == 1 && full == 0 && ovf == 0, "R8 reset fifo flags", {empty, full, ovf}, 3'b100);

        dir = 1; @(negedge clk);
        chk(io_oe == 1'b1, "R7 drive", io_oe, 1);
        for (int i = 0; i < DEPTH; i++) begin
            wr = 1; wdata = tx_byte(i); @(negedge clk);
        end
        wr = 0;
        chk(full == 1'b1, "R8 full after depth writes", full, 1);
        chk(ovf == 1'b0, "R9 no overflow yet", ovf, 0);
        wr = 1; wdata = 8'h77; @(negedge clk); wr = 0;
        chk(ovf == 1'b1, "R9 overflow on full write", ovf, 1);
        chk(full == 1'b1, "R9 still full", full, 1);

        for (int f = 0; f < 6; f++) tx_frame(9, f);
        tx_frame(17, 6);
        chk(empty == 1'b1, "R8 empty after all bytes", empty, 1);
        chk(ovf == 1'b1, "R9 overflow sticky", ovf, 1);

        for (int j = 0; j < 6; j++) rx_frame(8'((j * 91 + 33) & 255));
        rx_frame(8'h00);
        rx_frame(8'hFF);

        ack_frame(1'b1, 1'b0, 1'b0);
        ack_frame(1'b1, 1'b1, 1'b1);
        ack_frame(1'b0, 1'b0, 1'b1);

        stop = 1; lvl = 0; @(negedge clk);
        chk(card_clk == 1'b0, "R2 stop level low", card_clk, 0);
        begin
            logic [LW-1:0] c0;
            c0 = cnt;
            repeat (10) @(negedge clk);
            chk(card_clk == 1'b0, "R2 clock frozen", card_clk, 0);
            chk(cnt == c0, "R2 count frozen", cnt, c0);
        end

        tx = 1; len_v = 8'd5; reload = 1; stop = 0;
        for (int r = 0; r < 3; r++) begin
            wait_fall();
            chk(cnt == 0, "R3 reload beats advance", cnt, 0);
        end
        reload = 0;
        wait_fall();
        chk(cnt == 1, "R3 advance after reload", cnt, 1);
        end_frame();

        start_frame(3, 1'b0);
        irq_clr = 1;
        for (int k = 1; k <= 3; k++) wait_fall();
        chk(cnt == 3, "R4 short frame limit", cnt, 3);
        chk(irq == 1'b1, "R5 set wins over clear", irq, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R5 clear next cycle", irq, 0);
        irq_clr = 0;
        end_frame();

        ovr = 1; tx = 0; @(negedge clk);
        chk(io_o == 1'b1, "R6 rx mode follows override", io_o, 1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule